// File: doc/BRIEF.md
# DRAM Bank Command Timing Guard

This block sits between the command scheduler of a DDR2 memory controller and the command bus. It watches every command the scheduler issues and keeps, for each bank, a set of gap timers. It also keeps a few timers shared by all banks. From these it reports, for the bank currently shown on its bank input, which command types may legally go out in the present cycle. The scheduler reads the allow vector for a candidate bank and only issues a command whose bit is set.

Every minimum spacing is a parameter counted in clock cycles. The defaults are the nanosecond limits of a 2.5 ns clock, rounded up. A command that is issued while its allow bit is low is still taken into account by the timers, and it produces a one-cycle violation pulse. A row that stays open past its maximum lifetime sets a per-bank overdue flag so that the scheduler can close it. The flag never blocks a command.

Top module: `ddr_bank_timing_guard`

## Requirements
- R1: After reset all banks are closed and every timer has expired. The allow vector is 6'b110011 (NOP, ACT, PRE and MRS allowed; RD and WR blocked), violation is 0 and row_overdue is all zero.
- R2: Command codes are NOP=0, ACT=1, RD=2, WR=3, PRE=4, MRS=5, and allow bit i belongs to code i. Allow bit 0 is always 1. Codes 6 and 7 are treated as no operation: they change no state and never raise a violation.
- R3: ACT to a bank is allowed only while that bank is closed, at least T_RRD (3) cycles after any ACT, and at least T_RP (5) cycles after a PRE to that bank.
- R4: RD and WR to a bank are allowed only while it is open, at least T_RCD (5) cycles after its ACT, and at least T_CCD (2) cycles after any RD or WR.
- R5: RD is blocked until T_WDONE+T_WTR (9) cycles after any WR.
- R6: PRE to a bank waits T_RAS (18) cycles after its ACT, T_WDONE+T_WR (12) cycles after a WR to it, and T_RTP (3) cycles after a RD to it. PRE closes the bank.
- R7: A RD or WR with cmd_ap set closes its bank. The next ACT to that bank waits T_WDONE+T_WR+T_RP (17) cycles after such a WR, and T_RTP+T_RP (8) cycles after such a RD.
- R8: MRS is allowed only when every bank is closed with its precharge delay over, and at least T_MRD (2) cycles after the previous MRS.
- R9: A valid command with code 0..5 whose allow bit is low gives violation=1 in the next cycle for exactly one cycle. Its effect on bank state and timers is the same as for a legal command.
- R10: row_overdue[b] is 1 from T_RAS_MAX cycles after the last ACT to bank b for as long as b stays open. It drops in the cycle after the bank closes and never blocks any command.
- R11: The allow vector is computed for the bank on cmd_bank, and each bank's open state and timers are independent of the other banks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_code | input | 3 | Command type (NOP, ACT, RD, WR, PRE, MRS) |
| cmd_bank | input | $clog2(NBANK) | Target bank; also selects the bank the allow vector reports on |
| cmd_ap | input | 1 | Auto-precharge request on RD or WR |
| cmd_allow | output | 6 | Per-command-type permission for the bank on cmd_bank |
| violation | output | 1 | One-cycle pulse after a blocked command was issued |
| row_overdue | output | NBANK | Per-bank flag: row open beyond its maximum time |

## Verification
The directed part uses short, exact gap patterns. These are back-to-back activates to two banks, write followed by read, write followed by precharge, auto-precharge write followed by activate, and a mode-register pair. For each pattern the bench probes the cycle just before and the cycle just after the limit, which catches an off-by-one in any single gap. Probing one bank while another is busy separates per-bank state from shared state. The random part mixes legal traffic with deliberately blocked commands on random banks and auto-precharge flags. It compares the whole allow vector, the violation pulse and the overdue flags every cycle against a model that stores an earliest-legal cycle for each rule, so that interactions between overlapping rules are also exercised.

// File: rtl/tg_pkg.sv
package tg_pkg;

   typedef enum logic [2:0] {
      CMD_NOP = 3'd0,
      CMD_ACT = 3'd1,
      CMD_RD  = 3'd2,
      CMD_WR  = 3'd3,
      CMD_PRE = 3'd4,
      CMD_MRS = 3'd5
   } tg_cmd_e;

   localparam int TG_CW   = 3;
   localparam int TG_NCMD = 6;

   function automatic int tg_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/tg_gap_timer.sv
// Down counter holding the remaining cycles before a gap rule is met.
// A load keeps the longer of the pending and the requested wait.
module tg_gap_timer #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         ready
);

   if (W < 1) begin : g_bad_w
      $error("tg_gap_timer: W must be at least 1");
   end

   logic [W-1:0] cnt_q;
   logic [W-1:0] dec;
   logic [W-1:0] nxt;

   always_comb begin
      dec = (cnt_q == '0) ? '0 : cnt_q - W'(1);
      nxt = dec;
      if (load && (load_val > dec)) nxt = load_val;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= nxt;
   end

   assign ready = (cnt_q == '0);

   AST_LOAD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (load && load_val != '0) |=> !ready); // R6

endmodule

// File: rtl/tg_bank_track.sv
// Per-bank open state, gap timers and open-row age.
module tg_bank_track #(
   parameter int TW        = 5,
   parameter int AW        = 15,
   parameter int T_RAS     = 18,
   parameter int T_RCD     = 5,
   parameter int T_RP      = 5,
   parameter int T_WR      = 6,
   parameter int T_RTP     = 3,
   parameter int T_WDONE   = 6,
   parameter int T_RAS_MAX = 28000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic act,
   input  logic rd,
   input  logic wr,
   input  logic pre,
   input  logic ap,
   output logic is_open,
   output logic act_ok,
   output logic col_ok,
   output logic pre_ok,
   output logic overdue
);

   localparam int RP_AFTER_WRA = T_WDONE + T_WR + T_RP;
   localparam int RP_AFTER_RDA = T_RTP + T_RP;

   logic          open_q;
   logic [AW-1:0] age_q;
   logic          closing;
   logic          rp_load;
   logic [TW-1:0] rp_val;
   logic          ras_ok, wrp_ok, rtp_ok;

   assign closing = pre || ((rd || wr) && ap);

   always_ff @(posedge clk) begin
      if (!rst_n)       open_q <= 1'b0;
      else if (act)     open_q <= 1'b1;
      else if (closing) open_q <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                                 age_q <= '0;
      else if (act)                               age_q <= AW'(1);
      else if (open_q && age_q < AW'(T_RAS_MAX))  age_q <= age_q + AW'(1);
   end

   assign overdue = open_q && (age_q >= AW'(T_RAS_MAX));
   assign is_open = open_q;

   always_comb begin
      rp_load = closing;
      if (wr && ap)      rp_val = TW'(RP_AFTER_WRA - 1);
      else if (rd && ap) rp_val = TW'(RP_AFTER_RDA - 1);
      else               rp_val = TW'(T_RP - 1);
   end

   tg_gap_timer #(.W(TW)) u_ras (
      .clk(clk), .rst_n(rst_n), .load(act), .load_val(TW'(T_RAS - 1)), .ready(ras_ok));
   tg_gap_timer #(.W(TW)) u_rcd (
      .clk(clk), .rst_n(rst_n), .load(act), .load_val(TW'(T_RCD - 1)), .ready(col_ok));
   tg_gap_timer #(.W(TW)) u_wrp (
      .clk(clk), .rst_n(rst_n), .load(wr), .load_val(TW'(T_WDONE + T_WR - 1)), .ready(wrp_ok));
   tg_gap_timer #(.W(TW)) u_rtp (
      .clk(clk), .rst_n(rst_n), .load(rd), .load_val(TW'(T_RTP - 1)), .ready(rtp_ok));
   tg_gap_timer #(.W(TW)) u_rp (
      .clk(clk), .rst_n(rst_n), .load(rp_load), .load_val(rp_val), .ready(act_ok));

   assign pre_ok = ras_ok && wrp_ok && rtp_ok;

   AST_OD_NOT_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
      act |=> !overdue); // R10
   AST_AP_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && ap && !act) |=> !is_open); // R7
   AST_PRE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      (pre && !act) |=> (!is_open && !act_ok)); // R6

endmodule

// File: rtl/tg_bus_track.sv
// Gap timers shared by all banks: ACT-ACT, column-column, WR-RD, MRS-MRS.
module tg_bus_track #(
   parameter int TW      = 5,
   parameter int T_RRD   = 3,
   parameter int T_CCD   = 2,
   parameter int T_WDONE = 6,
   parameter int T_WTR   = 3,
   parameter int T_MRD   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic act_any,
   input  logic col_any,
   input  logic wr_any,
   input  logic mrs,
   output logic rrd_ok,
   output logic ccd_ok,
   output logic wtr_ok,
   output logic mrd_ok
);

   localparam int NT = 4;

   logic [NT-1:0]         ld;
   logic [NT-1:0][TW-1:0] val;
   logic [NT-1:0]         rdy;

   assign ld     = {mrs, wr_any, col_any, act_any};
   assign val[0] = TW'(T_RRD - 1);
   assign val[1] = TW'(T_CCD - 1);
   assign val[2] = TW'(T_WDONE + T_WTR - 1);
   assign val[3] = TW'(T_MRD - 1);

   for (genvar i = 0; i < NT; i++) begin : g_tmr
      tg_gap_timer #(.W(TW)) u_tmr (
         .clk(clk), .rst_n(rst_n), .load(ld[i]), .load_val(val[i]), .ready(rdy[i]));
   end

   assign rrd_ok = rdy[0];
   assign ccd_ok = rdy[1];
   assign wtr_ok = rdy[2];
   assign mrd_ok = rdy[3];

endmodule

// File: rtl/ddr_bank_timing_guard.sv
module ddr_bank_timing_guard
   import tg_pkg::*;
#(
   parameter int NBANK     = 4,
   parameter int T_RAS     = 18,
   parameter int T_RAS_MAX = 28000,
   parameter int T_RCD     = 5,
   parameter int T_RP      = 5,
   parameter int T_RRD     = 3,
   parameter int T_CCD     = 2,
   parameter int T_WR      = 6,
   parameter int T_WTR     = 3,
   parameter int T_RTP     = 3,
   parameter int T_WDONE   = 6,
   parameter int T_MRD     = 2,
   localparam int BW       = $clog2(NBANK)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_valid,
   input  logic [TG_CW-1:0]     cmd_code,
   input  logic [BW-1:0]        cmd_bank,
   input  logic                 cmd_ap,
   output logic [TG_NCMD-1:0]   cmd_allow,
   output logic                 violation,
   output logic [NBANK-1:0]     row_overdue
);

   localparam int TMAX = tg_max(tg_max(tg_max(T_RAS, T_WDONE + T_WR + T_RP),
                                       tg_max(T_RTP + T_RP, T_WDONE + T_WTR)),
                                tg_max(tg_max(T_RRD, T_CCD), tg_max(T_MRD, T_RCD)));
   localparam int TW   = $clog2(TMAX + 1);
   localparam int AW   = $clog2(T_RAS_MAX + 1);
   localparam int NEXT = 2 ** TG_CW;

   if (NBANK < 2 || (NBANK & (NBANK - 1)) != 0) begin : g_bad_nbank
      $error("ddr_bank_timing_guard: NBANK must be a power of two, at least 2");
   end
   if (T_RAS < 1 || T_RCD < 1 || T_RP < 1 || T_RRD < 1 || T_CCD < 1 ||
       T_WR < 1 || T_WTR < 1 || T_RTP < 1 || T_WDONE < 0 || T_MRD < 1) begin : g_bad_gap
      $error("ddr_bank_timing_guard: every gap must be at least one cycle");
   end
   if (T_RAS_MAX < 2) begin : g_bad_rasmax
      $error("ddr_bank_timing_guard: T_RAS_MAX must be at least 2");
   end

   logic is_act, is_rd, is_wr, is_pre, is_mrs;

   assign is_act = cmd_valid && (cmd_code == CMD_ACT);
   assign is_rd  = cmd_valid && (cmd_code == CMD_RD);
   assign is_wr  = cmd_valid && (cmd_code == CMD_WR);
   assign is_pre = cmd_valid && (cmd_code == CMD_PRE);
   assign is_mrs = cmd_valid && (cmd_code == CMD_MRS);

   logic [NBANK-1:0] open_v, actok_v, colok_v, preok_v;

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic hit;
      assign hit = (cmd_bank == BW'(b));

      tg_bank_track #(
         .TW(TW), .AW(AW), .T_RAS(T_RAS), .T_RCD(T_RCD), .T_RP(T_RP),
         .T_WR(T_WR), .T_RTP(T_RTP), .T_WDONE(T_WDONE), .T_RAS_MAX(T_RAS_MAX)
      ) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .act     (is_act && hit),
         .rd      (is_rd && hit),
         .wr      (is_wr && hit),
         .pre     (is_pre && hit),
         .ap      (cmd_ap),
         .is_open (open_v[b]),
         .act_ok  (actok_v[b]),
         .col_ok  (colok_v[b]),
         .pre_ok  (preok_v[b]),
         .overdue (row_overdue[b])
      );
   end

   logic rrd_ok, ccd_ok, wtr_ok, mrd_ok;

   tg_bus_track #(
      .TW(TW), .T_RRD(T_RRD), .T_CCD(T_CCD), .T_WDONE(T_WDONE),
      .T_WTR(T_WTR), .T_MRD(T_MRD)
   ) u_bus (
      .clk     (clk),
      .rst_n   (rst_n),
      .act_any (is_act),
      .col_any (is_rd || is_wr),
      .wr_any  (is_wr),
      .mrs     (is_mrs),
      .rrd_ok  (rrd_ok),
      .ccd_ok  (ccd_ok),
      .wtr_ok  (wtr_ok),
      .mrd_ok  (mrd_ok)
   );

   logic sel_open, sel_actok, sel_colok, sel_preok, all_idle;

   assign sel_open  = open_v[cmd_bank];
   assign sel_actok = actok_v[cmd_bank];
   assign sel_colok = colok_v[cmd_bank];
   assign sel_preok = preok_v[cmd_bank];
   assign all_idle  = (open_v == '0) && (&actok_v);

   always_comb begin
      cmd_allow          = '0;
      cmd_allow[CMD_NOP] = 1'b1;
      cmd_allow[CMD_ACT] = !sel_open && sel_actok && rrd_ok;
      cmd_allow[CMD_RD]  = sel_open && sel_colok && ccd_ok && wtr_ok;
      cmd_allow[CMD_WR]  = sel_open && sel_colok && ccd_ok;
      cmd_allow[CMD_PRE] = sel_preok;
      cmd_allow[CMD_MRS] = all_idle && mrd_ok;
   end

   logic [NEXT-1:0] allow_ext;
   logic            viol_q;

   assign allow_ext = {{(NEXT - TG_NCMD){1'b1}}, cmd_allow};

   always_ff @(posedge clk) begin
      if (!rst_n) viol_q <= 1'b0;
      else        viol_q <= cmd_valid && !allow_ext[cmd_code];
   end

   assign violation = viol_q;

   if (T_RRD > 1) begin : g_ast_rrd
      AST_RRD_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
         is_act |=> !cmd_allow[CMD_ACT]); // R3
   end
   if (T_CCD > 1) begin : g_ast_ccd
      AST_CCD_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
         (is_rd || is_wr) |=> (!cmd_allow[CMD_RD] && !cmd_allow[CMD_WR])); // R4
   end
   if (T_MRD > 1) begin : g_ast_mrd
      AST_MRD_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
         is_mrs |=> !cmd_allow[CMD_MRS]); // R8
   end
   if (T_WDONE + T_WTR > 1) begin : g_ast_wtr
      AST_WTR_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
         is_wr |=> !cmd_allow[CMD_RD]); // R5
   end
   AST_VIOL_ON_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (is_pre && !cmd_allow[CMD_PRE]) |=> violation); // R9
   AST_SPARE_CODES_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_code > 3'd5) |=> !violation); // R2
   AST_NOP_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_allow[CMD_NOP]); // R2

endmodule

// File: tb/ddr_bank_timing_guard_tb_top.sv
module ddr_bank_timing_guard_tb_top;
   import tg_pkg::*;

   localparam int NB     = 4;
   localparam int BW     = 2;
   localparam int RASMAX = 40;
   // Independent copies of the cycle limits from the requirements
   localparam int G_RAS = 18, G_RCD = 5, G_RP = 5, G_RRD = 3, G_CCD = 2;
   localparam int G_WR = 6, G_WTR = 3, G_RTP = 3, G_WDONE = 6, G_MRD = 2;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cmd_valid;
   logic [2:0]    cmd_code;
   logic [BW-1:0] cmd_bank;
   logic          cmd_ap;
   logic [5:0]    cmd_allow;
   logic          violation;
   logic [NB-1:0] row_overdue;

   always #5 clk = ~clk;

   ddr_bank_timing_guard #(.NBANK(NB), .T_RAS_MAX(RASMAX)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .cmd_bank(cmd_bank), .cmd_ap(cmd_ap), .cmd_allow(cmd_allow),
      .violation(violation), .row_overdue(row_overdue));

   int checks = 0;
   int errors = 0;

   // Reference model: earliest legal cycle for each rule
   int cyc;
   bit m_open [NB];
   int e_rp [NB], e_rcd [NB], e_ras [NB], e_wrp [NB], e_rtp [NB], t_act [NB];
   int e_rrd, e_ccd, e_wtr, e_mrd;
   bit exp_viol;

   logic [5:0]    obs_allow;
   logic          obs_viol;
   logic [NB-1:0] obs_od;

   function automatic int later(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic logic [5:0] model_allow(input int b);
      logic [5:0] a;
      bit idle;
      idle = 1'b1;
      for (int i = 0; i < NB; i++) if (m_open[i] || cyc < e_rp[i]) idle = 1'b0;
      a[0] = 1'b1;
      a[1] = !m_open[b] && cyc >= e_rp[b] && cyc >= e_rrd;
      a[2] = m_open[b] && cyc >= e_rcd[b] && cyc >= e_ccd && cyc >= e_wtr;
      a[3] = m_open[b] && cyc >= e_rcd[b] && cyc >= e_ccd;
      a[4] = cyc >= e_ras[b] && cyc >= e_wrp[b] && cyc >= e_rtp[b];
      a[5] = idle && cyc >= e_mrd;
      return a;
   endfunction

   function automatic logic [NB-1:0] model_od();
      logic [NB-1:0] o;
      for (int i = 0; i < NB; i++) o[i] = m_open[i] && (cyc - t_act[i] >= RASMAX);
      return o;
   endfunction

   function automatic string tag_of(input int k);
      case (k)
         1: return "R3";
         2: return "R4";
         3: return "R4";
         4: return "R6";
         5: return "R8";
         default: return "R2";
      endcase
   endfunction

   task automatic model_apply(input logic [2:0] code, input int b, input bit ap);
      case (code)
         3'd1: begin
            m_open[b] = 1'b1; t_act[b] = cyc;
            e_ras[b] = later(e_ras[b], cyc + G_RAS);
            e_rcd[b] = later(e_rcd[b], cyc + G_RCD);
            e_rrd    = later(e_rrd, cyc + G_RRD);
         end
         3'd2: begin
            e_ccd    = later(e_ccd, cyc + G_CCD);
            e_rtp[b] = later(e_rtp[b], cyc + G_RTP);
            if (ap) begin m_open[b] = 1'b0; e_rp[b] = later(e_rp[b], cyc + G_RTP + G_RP); end
         end
         3'd3: begin
            e_ccd    = later(e_ccd, cyc + G_CCD);
            e_wtr    = later(e_wtr, cyc + G_WDONE + G_WTR);
            e_wrp[b] = later(e_wrp[b], cyc + G_WDONE + G_WR);
            if (ap) begin
               m_open[b] = 1'b0;
               e_rp[b] = later(e_rp[b], cyc + G_WDONE + G_WR + G_RP);
            end
         end
         3'd4: begin
            m_open[b] = 1'b0; e_rp[b] = later(e_rp[b], cyc + G_RP);
         end
         3'd5: e_mrd = later(e_mrd, cyc + G_MRD);
         default: ;
      endcase
   endtask

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s cycle=%0d actual=%0d expected=%0d", tag, what, cyc, act, exp);
      end
   endtask

   // One clock cycle: drive, compare all outputs with the model, update model
   task automatic step(input bit v, input logic [2:0] code, input int b, input bit ap);
      logic [5:0]    ea;
      logic [7:0]    ea_x;
      logic [NB-1:0] eo;
      @(negedge clk);
      cmd_valid = v; cmd_code = code; cmd_bank = b[BW-1:0]; cmd_ap = ap;
      #2;
      ea = model_allow(b);
      eo = model_od();
      obs_allow = cmd_allow; obs_viol = violation; obs_od = row_overdue;
      for (int k = 0; k < 6; k++)
         chk(cmd_allow[k] == ea[k], tag_of(k), $sformatf("allow[%0d] bank %0d", k, b),
             int'(cmd_allow[k]), int'(ea[k]));
      chk(violation == exp_viol, "R9", "violation", int'(violation), int'(exp_viol));
      chk(row_overdue == eo, "R10", "row_overdue", int'(row_overdue), int'(eo));
      ea_x = {2'b11, ea};
      exp_viol = v && !ea_x[code];
      if (v) model_apply(code, b, ap);
      cyc++;
   endtask

   task automatic idle(input int n, input int b);
      for (int i = 0; i < n; i++) step(1'b0, 3'd0, b, 1'b0);
   endtask

   task automatic probe(input int b, input int k, input bit exp, input string tag);
      step(1'b0, 3'd0, b, 1'b0);
      chk(obs_allow[k] == exp, tag, $sformatf("probe allow[%0d] bank %0d", k, b),
          int'(obs_allow[k]), int'(exp));
   endtask

   initial begin
      #1000000;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [5:0] a;
      logic [2:0] c;
      int         b;
      bit         v, ap;
      void'($urandom(32'd4242));
      cyc = 0; exp_viol = 1'b0;
      e_rrd = 0; e_ccd = 0; e_wtr = 0; e_mrd = 0;
      for (int i = 0; i < NB; i++) begin
         m_open[i] = 0; e_rp[i] = 0; e_rcd[i] = 0; e_ras[i] = 0;
         e_wrp[i] = 0; e_rtp[i] = 0; t_act[i] = 0;
      end
      rst_n = 1'b0; cmd_valid = 1'b0; cmd_code = 3'd0; cmd_bank = '0; cmd_ap = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      step(1'b0, 3'd0, 0, 1'b0);
      chk(obs_allow == 6'b110011, "R1", "allow after reset", int'(obs_allow), 6'b110011);
      chk(obs_viol == 1'b0, "R1", "violation after reset", int'(obs_viol), 0);
      chk(obs_od == '0, "R1", "overdue after reset", int'(obs_od), 0);

      // R2: spare code is a no-op
      step(1'b1, 3'd7, 0, 1'b0);
      step(1'b0, 3'd0, 0, 1'b0);
      chk(obs_viol == 1'b0, "R2", "violation after code 7", int'(obs_viol), 0);
      chk(obs_allow[1] == 1'b1 && obs_allow[2] == 1'b0, "R2", "bank0 still closed",
          int'(obs_allow), 6'b110011);

      // R9: blocked read to a closed bank
      step(1'b1, 3'd2, 0, 1'b0);
      step(1'b0, 3'd0, 0, 1'b0);
      chk(obs_viol == 1'b1, "R9", "violation pulse", int'(obs_viol), 1);
      step(1'b0, 3'd0, 0, 1'b0);
      chk(obs_viol == 1'b0, "R9", "violation one cycle", int'(obs_viol), 0);

      // R3, R4, R11: activate spacing and per-bank state
      step(1'b1, 3'd1, 2, 1'b0);
      probe(3, 1, 1'b0, "R3");
      probe(3, 1, 1'b0, "R3");
      probe(3, 1, 1'b1, "R3");
      probe(2, 2, 1'b0, "R4");
      probe(2, 2, 1'b1, "R4");
      probe(3, 2, 1'b0, "R11");

      // R5, R6: write to read and write to precharge
      step(1'b1, 3'd3, 2, 1'b0);
      idle(7, 2);
      probe(2, 2, 1'b0, "R5");
      probe(2, 2, 1'b1, "R5");
      idle(1, 2);
      probe(2, 4, 1'b0, "R6");
      probe(2, 4, 1'b1, "R6");

      // R7: write with auto-precharge then activate
      step(1'b1, 3'd1, 1, 1'b0);
      idle(4, 1);
      step(1'b1, 3'd3, 1, 1'b1);
      idle(15, 1);
      probe(1, 1, 1'b0, "R7");
      probe(1, 1, 1'b1, "R7");

      // R8: mode register commands
      probe(0, 5, 1'b0, "R8");
      step(1'b1, 3'd4, 2, 1'b0);
      idle(4, 0);
      probe(0, 5, 1'b1, "R8");
      step(1'b1, 3'd5, 0, 1'b0);
      probe(0, 5, 1'b0, "R8");
      probe(0, 5, 1'b1, "R8");

      // R10: overdue open row
      step(1'b1, 3'd1, 0, 1'b0);
      idle(38, 0);
      step(1'b0, 3'd0, 0, 1'b0);
      chk(obs_od[0] == 1'b0, "R10", "overdue before limit", int'(obs_od[0]), 0);
      step(1'b0, 3'd0, 0, 1'b0);
      chk(obs_od[0] == 1'b1, "R10", "overdue at limit", int'(obs_od[0]), 1);
      chk(obs_allow[4] == 1'b1, "R10", "precharge not blocked", int'(obs_allow[4]), 1);
      step(1'b1, 3'd4, 0, 1'b0);
      step(1'b0, 3'd0, 0, 1'b0);
      chk(obs_od[0] == 1'b0, "R10", "overdue cleared", int'(obs_od[0]), 0);

      // R9: blocked activate still opens the bank
      step(1'b1, 3'd1, 3, 1'b0);
      step(1'b1, 3'd1, 0, 1'b0);
      step(1'b0, 3'd0, 0, 1'b0);
      chk(obs_viol == 1'b1, "R9", "blocked activate flagged", int'(obs_viol), 1);
      chk(obs_allow[1] == 1'b0, "R9", "blocked activate opened bank", int'(obs_allow[1]), 0);
      step(1'b0, 3'd0, 0, 1'b0);
      chk(obs_viol == 1'b0, "R9", "pulse ends", int'(obs_viol), 0);

      // Constrained random traffic, mostly legal
      for (int n = 0; n < 3000; n++) begin
         c  = 3'($urandom % 8);
         b  = int'($urandom % NB);
         ap = 1'($urandom % 2);
         v  = ($urandom % 4) != 0;
         a  = model_allow(b);
         if (v && c < 3'd6 && !a[c] && ($urandom % 5) != 0) v = 1'b0;
         step(v, c, b, ap);
      end
      step(1'b0, 3'd0, 0, 1'b0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule